// File: doc/BRIEF.md
# Prescaled Bus Stall Watchdog

This block watches a bus transfer for stalls, such as a clock line held low by a slow or stuck device. A protocol engine drives a `stall_i` level while the bus is waiting on such a condition. While the watchdog is armed and `stall_i` is high, a down-counter runs. It steps once per tick, and a tick lasts a power-of-two number of input clocks. If the count runs out, a sticky timeout flag is set. That flag can raise an interrupt line, and software clears it by writing a one to its bit.

Software programs the block through a simple write-only port with four selectable targets: a control word holding a 15-bit reload value and an arm bit, a log2 prescaler, an interrupt mask, and a flag-clear word. Software chooses the smallest prescale at which the tick count for its stall limit fits in 15 bits. A typical limit is about 25 ms. Software can disarm the timer around the start of a command by writing the control word with the arm bit low, which keeps the reload value. It re-arms by writing the arm bit high again.

The core is a four-state machine:
- `WD_OFF`: the timer is disarmed.
- `WD_WATCH`: the timer is armed, the bus is not stalled, and the counter is held at the reload value.
- `WD_COUNT`: the bus is stalled and the counter steps down on each tick.
- `WD_EXPIRED`: the limit was reached during the current stall.

The transitions are:
- From any state, the machine goes to `WD_OFF` when the arm bit is low.
- From `WD_OFF` with the arm bit high, it goes to `WD_COUNT` if `stall_i` is high, or to `WD_WATCH` if not. Either way it loads the reload value.
- From `WD_WATCH`, it goes to `WD_COUNT` when `stall_i` rises, loading the reload value.
- From `WD_COUNT` or `WD_EXPIRED`, it goes to `WD_WATCH` when `stall_i` falls.
- From `WD_COUNT`, it goes to `WD_EXPIRED` on a tick that finds the counter at zero.

Top module: `wdt_stall_timer`

## Requirements
- R1: After reset the reload value, arm bit, prescale and mask are all zero. `tmo_flag_o` and `irq_o` are low. With the arm bit at its reset value of zero, a stall never sets the flag.
- R2: The control word (select 0) carries the reload value V in bits 14:0 and the arm bit in bit 15. The prescale word (select 1) carries P in bits 3:0, and one tick is 2^P clocks. Let edge k be the first clock edge at which the armed machine samples `stall_i` high. If `stall_i` stays high, the flag rises at edge k + (V+1)·2^P and not before. This holds up to V = 0x7FFF.
- R3: A prescale write above 14 is stored as 14, so the longest tick is 16384 clocks.
- R4: A reload value of zero sets the flag on the first tick of a stall, at edge k + 2^P.
- R5: When `stall_i` falls, the counter reloads V and the prescaler restarts. A later stall times out after the full (V+1)·2^P clocks again.
- R6: With the arm bit clear, a stall of any length sets no flag. Writing the arm bit from 0 to 1 reloads the counter, and counting starts at the next edge if `stall_i` is already high.
- R7: The flag is sticky. A write to select 3 with bit 7 set clears it. A select-3 write with bit 7 clear leaves it unchanged. If an expiry and a clear arrive in the same cycle, the expiry wins.
- R8: `irq_o` is high exactly when the flag is set and bit 7 of the mask word (select 2) is set.
- R9: Each stall episode sets the flag at most once. After expiry, clearing the flag while `stall_i` stays high does not set it again until `stall_i` has fallen and risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Write target: 0 control, 1 prescale, 2 mask, 3 flag clear |
| cfg_wdata_i | input | 16 | Write data |
| stall_i | input | 1 | Bus stall condition from the protocol engine |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Timeout interrupt, flag gated by mask |

## Verification
The hardest behaviours to reach from the ports are the two that involve history inside a stall.

The first is the reload after a short drop of `stall_i` in the middle of a count. The stimulus runs a stall for part of its window, drops it for a single cycle, then restarts it. The bench then checks that the flag is still low at the full window measured from the restart. Without the reload, the flag would already be set at that point.

The second is the single-shot rule after expiry. The stimulus clears the flag while `stall_i` is held high and watches for a long interval before releasing the stall.

The longest tick is reached by writing an out-of-range prescale, which also exercises the clamp.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int VAL_W    = 15;
    localparam int PRE_W    = 4;
    localparam int PRE_MAX  = 14;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 2;
    localparam int FLAG_BIT = 7;
    localparam int ARM_BIT  = VAL_W;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_PRE   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MASK  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CLEAR = 2'd3;

    typedef enum logic [1:0] {
        WD_OFF      = 2'd0,
        WD_WATCH    = 2'd1,
        WD_COUNT    = 2'd2,
        WD_EXPIRED  = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_pkg::*;
#(
    parameter int VW   = VAL_W,
    parameter int PW   = PRE_W,
    parameter int PMAX = PRE_MAX,
    parameter int DW   = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [VW-1:0]    reload_o,
    output logic             arm_o,
    output logic [PW-1:0]    prescale_o,
    output logic             mask_o,
    output logic             clear_o
);
    localparam logic [PW-1:0] PCLAMP = PW'(PMAX);

    logic [PW-1:0] pre_in;
    assign pre_in = wdata_i[PW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_o   <= '0;
            arm_o      <= 1'b0;
            prescale_o <= '0;
            mask_o     <= 1'b0;
        end else if (wr_i) begin
            unique case (sel_i)
                SEL_CTRL: begin
                    reload_o <= wdata_i[VW-1:0];
                    arm_o    <= wdata_i[VW];
                end
                SEL_PRE:   prescale_o <= (pre_in > PCLAMP) ? PCLAMP : pre_in;
                SEL_MASK:  mask_o     <= wdata_i[FLAG_BIT];
                SEL_CLEAR: ;
            endcase
        end
    end

    assign clear_o = wr_i && (sel_i == SEL_CLEAR) && wdata_i[FLAG_BIT];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PW   = PRE_W,
    parameter int PMAX = PRE_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] prescale_i,
    output logic          tick_o
);
    localparam int CW = (PMAX > 0) ? PMAX : 1;

    logic [CW-1:0] div_q;
    logic [CW-1:0] span;

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            span[i] = (i < int'(prescale_i));
        end
    end

    assign tick_o = run_i && ((div_q & span) == span);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int VW = VAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          stall_i,
    input  logic [VW-1:0] reload_i,
    input  logic          tick_i,
    output logic          run_o,
    output logic          expire_o,
    output wd_state_t     state_o
);
    wd_state_t     state_q, state_d;
    logic [VW-1:0] cnt_q;
    logic          load, step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_i;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step     = 1'b0;
        expire_o = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (arm_i) begin
                    load    = 1'b1;
                    state_d = stall_i ? WD_COUNT : WD_WATCH;
                end
            end
            WD_WATCH: begin
                load = 1'b1;
                if (!arm_i) begin
                    state_d = WD_OFF;
                end else if (stall_i) begin
                    state_d = WD_COUNT;
                end
            end
            WD_COUNT: begin
                if (!arm_i) begin
                    state_d = WD_OFF;
                end else if (!stall_i) begin
                    load    = 1'b1;
                    state_d = WD_WATCH;
                end else if (tick_i) begin
                    if (cnt_q == '0) begin
                        expire_o = 1'b1;
                        state_d  = WD_EXPIRED;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            WD_EXPIRED: begin
                if (!arm_i) begin
                    state_d = WD_OFF;
                end else if (!stall_i) begin
                    load    = 1'b1;
                    state_d = WD_WATCH;
                end
            end
        endcase
    end

    assign run_o   = (state_q == WD_COUNT) && arm_i && stall_i;
    assign state_o = state_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    input  logic mask_i,
    output logic flag_o,
    output logic irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clear_i) begin
            flag_o <= 1'b0;
        end
    end

    assign irq_o = flag_o && mask_i;
endmodule

// File: rtl/wdt_stall_timer.sv
module wdt_stall_timer
    import wdt_pkg::*;
#(
    parameter int VW   = VAL_W,
    parameter int PW   = PRE_W,
    parameter int PMAX = PRE_MAX,
    parameter int DW   = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [DW-1:0]    cfg_wdata_i,
    input  logic             stall_i,
    output logic             tmo_flag_o,
    output logic             irq_o
);
    logic [VW-1:0] reload;
    logic          enable;
    logic [PW-1:0] prescale;
    logic          mask;
    logic          clear;
    logic          run;
    logic          tick;
    logic          expire;
    wd_state_t     state;

    wdt_cfg_regs #(.VW(VW), .PW(PW), .PMAX(PMAX), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .reload_o   (reload),
        .arm_o      (enable),
        .prescale_o (prescale),
        .mask_o     (mask),
        .clear_o    (clear)
    );

    wdt_prescaler #(.PW(PW), .PMAX(PMAX)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .prescale_i (prescale),
        .tick_o     (tick)
    );

    wdt_countdown #(.VW(VW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (enable),
        .stall_i  (stall_i),
        .reload_i (reload),
        .tick_i   (tick),
        .run_o    (run),
        .expire_o (expire),
        .state_o  (state)
    );

    wdt_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (expire),
        .clear_i (clear),
        .mask_i  (mask),
        .flag_o  (tmo_flag_o),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/wdt_stall_timer_chk.sv
module wdt_stall_timer_chk
    import wdt_pkg::*;
#(
    parameter int PW   = PRE_W,
    parameter int PMAX = PRE_MAX,
    parameter int DW   = DATA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_i,
    input logic [SEL_W-1:0] cfg_sel_i,
    input logic [DW-1:0]    cfg_wdata_i,
    input logic             stall_i,
    input logic             tmo_flag_o,
    input logic             irq_o,
    input logic             enable,
    input logic [PW-1:0]    prescale,
    input logic             expire,
    input wd_state_t        state
);
    logic clr_wr, mask_on_wr;
    assign clr_wr     = cfg_wr_i && (cfg_sel_i == SEL_CLEAR) && cfg_wdata_i[FLAG_BIT];
    assign mask_on_wr = cfg_wr_i && (cfg_sel_i == SEL_MASK) && cfg_wdata_i[FLAG_BIT];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!tmo_flag_o && !irq_o));

    assert_rise_needs_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag_o) |-> ($past(stall_i) && $past(enable)));

    assert_prescale_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prescale <= PW'(PMAX));

    assert_disarmed_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag_o && !clr_wr) |=> tmo_flag_o);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !tmo_flag_o);

    assert_irq_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_on_wr && tmo_flag_o) |=> irq_o);

    assert_single_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_EXPIRED) |-> !expire);
endmodule

bind wdt_stall_timer wdt_stall_timer_chk #(.PW(PW), .PMAX(PMAX), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .stall_i     (stall_i),
    .tmo_flag_o  (tmo_flag_o),
    .irq_o       (irq_o),
    .enable      (enable),
    .prescale    (prescale),
    .expire      (expire),
    .state       (state)
);

// File: tb/tb_wdt_stall_timer.sv
`timescale 1ns/1ps
module tb_wdt_stall_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        stall = 1'b0;
    logic        flag, irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    due;
        bit    f;
        bit    i;
        string tag;
    } exp_t;
    exp_t q[$];

    wdt_stall_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .stall_i     (stall),
        .tmo_flag_o  (flag),
        .irq_o       (irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expectations as they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flag !== e.f || irq !== e.i) begin
                errors++;
                $display("FAIL %s cyc=%0d flag/irq actual=%b%b expected=%b%b",
                         e.tag, cyc, flag, irq, e.f, e.i);
            end
        end
    end

    task automatic expect_at(int dly, bit f, bit i, string tag);
        exp_t e;
        e.due = cyc + dly; e.f = f; e.i = i; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] d);
        cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = 16'd0;
    endtask

    // flag window measured from the current negedge, where the next edge is k
    task automatic window(int v, int p, bit irq_exp, string tag);
        int t;
        t = (v + 1) << p;
        expect_at(t, 1'b0, 1'b0, tag);
        expect_at(t + 1, 1'b1, irq_exp, tag);
        idle(t + 2);
    endtask

    task automatic quiesce();
        stall = 1'b0;
        idle(2);
        wr(2'd3, 16'h0080);
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_at(1, 1'b0, 1'b0, "R1 reset state");
        idle(2);
        // R1: arm bit resets to zero, so a stall sets nothing
        stall = 1'b1;
        expect_at(60, 1'b0, 1'b0, "R1 disarmed after reset");
        idle(62);
        stall = 1'b0;
        idle(2);

        // R2 / R8: P=0 V=3, interrupt unmasked
        wr(2'd2, 16'h0080);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h8003);
        stall = 1'b1;
        window(3, 0, 1'b1, "R2 R8 V=3 P=0");

        // R7: select-3 write with bit 7 clear is ignored
        wr(2'd3, 16'hFF7F);
        expect_at(1, 1'b1, 1'b1, "R7 clear without bit7 ignored");
        idle(2);
        wr(2'd3, 16'h0080);
        expect_at(1, 1'b0, 1'b0, "R7 W1C clears flag");
        // R9: stall still high, no refire
        expect_at(80, 1'b0, 1'b0, "R9 no second expiry in one stall");
        idle(82);
        quiesce();

        // R2 / R8: masked interrupt, P=2 V=5
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0002);
        wr(2'd0, 16'h8005);
        stall = 1'b1;
        window(5, 2, 1'b0, "R2 R8 V=5 P=2 masked");
        quiesce();

        // R4: zero reload, first tick
        wr(2'd2, 16'h0080);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h8000);
        stall = 1'b1;
        window(0, 0, 1'b1, "R4 zero value P=0");
        quiesce();
        wr(2'd1, 16'h0003);
        stall = 1'b1;
        window(0, 3, 1'b1, "R4 zero value P=3");
        quiesce();

        // R5: short drop of stall reloads
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h8003);
        stall = 1'b1;
        idle(5);
        stall = 1'b0;
        idle(1);
        stall = 1'b1;
        window(3, 1, 1'b1, "R5 reload after stall drop");
        quiesce();

        // R6: disarmed stall, then re-arm while stalled
        wr(2'd0, 16'h0002);
        stall = 1'b1;
        expect_at(50, 1'b0, 1'b0, "R6 disarmed long stall");
        idle(52);
        wr(2'd0, 16'h8002);
        window(2, 1, 1'b1, "R6 re-arm reloads");
        quiesce();

        // R3: prescale 15 stored as 14
        wr(2'd1, 16'h000F);
        wr(2'd0, 16'h8000);
        stall = 1'b1;
        window(0, 14, 1'b1, "R3 prescale clamp");
        quiesce();

        // R2: largest reload
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'hFFFF);
        stall = 1'b1;
        window(32767, 0, 1'b1, "R2 max value");
        quiesce();

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule